// File: doc/BRIEF.md
# Double-Buffered Decoder Phase Sequencer

This block sequences a decoding accelerator that has two input buffers, one execution core and two output buffers. Each block of data goes through three phases: a load into an input buffer, an execution that reads that input buffer and writes an output buffer, and an unload that drains the output buffer through the output port. The sequencer never touches data. It decides which buffer each phase uses, issues a one-cycle start pulse to the external load, core and unload engines, and frees a buffer when the engine that owns it reports done.

An input buffer is freed when execution of its block ends, not when the block leaves the accelerator. An output buffer is freed when its unload ends. As a result, the load of block n+2, the execution of block n+1 and the unload of block n can all run at once. Phase lengths depend on the job, so every phase ends on its done handshake and never after a fixed count.

Blocks run through execution and unload in the order they were loaded. A small queue of buffer indices for each buffer kind keeps that order.

Top module: `dec_buf_seq`

## Requirements
- R1: After synchronous reset, both input buffers and both output buffers are free, all three engines are idle and no start pulse is high; the first load uses input buffer 0.
- R2: `loadStart` is high in a cycle exactly when `inPortRdy` is high, no load is in progress and at least one input buffer is free; `loadBuf` is then the lowest free input index (0 before 1).
- R3: `execStart` is high in a cycle exactly when the core is idle, a loaded block is waiting and at least one output buffer is free; `execOutBuf` is then the lowest free output index.
- R4: An input buffer becomes free at the clock edge where the done of the execution reading it is accepted, and a load can use it from the next cycle.
- R5: `unloadStart` is high in a cycle exactly when `outPortRdy` is high, no unload is in progress and a finished result is waiting; the output buffer is freed at the edge where `unloadDone` is accepted.
- R6: The sequence of `execInBuf` values at exec starts equals the sequence of `loadBuf` values at completed loads, and the sequence of `unloadBuf` values at unload starts equals the sequence of `execOutBuf` values at completed executions.
- R7: A done input that arrives while its phase is not running is ignored: it frees no buffer and causes no start.
- R8: Each start is a single-cycle pulse. After a start, the same phase cannot start again until the cycle after its done is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inPortRdy | input | 1 | Input port can deliver a block |
| loadStart | output | 1 | One-cycle pulse that starts the load engine |
| loadBuf | output | 1 | Input buffer for the load, valid with loadStart |
| loadDone | input | 1 | Load engine finished the current load |
| execStart | output | 1 | One-cycle pulse that starts the core |
| execInBuf | output | 1 | Input buffer the core reads, valid with execStart |
| execOutBuf | output | 1 | Output buffer the core writes, valid with execStart |
| execDone | input | 1 | Core finished the current block |
| outPortRdy | input | 1 | Output port can accept a result |
| unloadStart | output | 1 | One-cycle pulse that starts the unload engine |
| unloadBuf | output | 1 | Output buffer to drain, valid with unloadStart |
| unloadDone | input | 1 | Unload engine finished the current unload |

## Verification
Suppose the sequencer lost track of which buffers are free or which engines are busy. The fault would show within a few cycles as a start pulse issued while its engine is running, a start missing when all of its conditions hold, or a buffer index that points at a buffer still in use. If an entry in an ordering queue were lost or duplicated, `execInBuf` or `unloadBuf` would break the load order at the next start of that phase. The bench keeps its own model of buffer ownership. It compares every start and index in every cycle while engines with random durations and random port readiness run, and it adds directed sequences for buffer reuse and for done inputs that arrive with no phase running.

// File: rtl/dec_buf_seq_pkg.sv
package dec_buf_seq_pkg;
  localparam int NBUF = 2;
  localparam int IDXW = (NBUF > 1) ? $clog2(NBUF) : 1;

  typedef logic [IDXW-1:0] bufIdx_t;
  typedef logic [NBUF-1:0] bufMask_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    doLoad;
    logic    doExec;
    logic    doUnload;
    logic    ldDoneOk;
    logic    exDoneOk;
    logic    unDoneOk;
    bufIdx_t loadIdx;
    bufIdx_t execOutIdx;
  } strobe_t;

  // ownership state from datapath to control
  typedef struct packed {
    bufMask_t inFree;
    bufMask_t outFree;
    logic     loadBusy;
    logic     coreBusy;
    logic     unloadBusy;
    logic     execQValid;
    bufIdx_t  execQHead;
    logic     outQValid;
    bufIdx_t  outQHead;
  } status_t;

  function automatic bufIdx_t lowestFree(input bufMask_t m);
    bufIdx_t r;
    r = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (m[i]) r = bufIdx_t'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/dec_buf_seq_idxq.sv
module dec_buf_seq_idxq #(
  parameter int DEPTH = 2,
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic         valid,
  output logic [W-1:0] head
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr <= '0;
      wrPtr <= '0;
      cnt   <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) begin
        mem[wrPtr] <= pushData;
        wrPtr      <= nextPtr(wrPtr);
      end
      if (pop) rdPtr <= nextPtr(rdPtr);
      if (push && !pop) cnt <= cnt + CW'(1);
      else if (pop && !push) cnt <= cnt - CW'(1);
    end
  end

  assign valid = (cnt != '0);
  assign head  = mem[rdPtr];

  // R6: ordering queue never overflows nor underflows
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt < CW'(DEPTH)) || pop);
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> valid);
endmodule

// File: rtl/dec_buf_seq_ctrl.sv
module dec_buf_seq_ctrl
  import dec_buf_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inPortRdy,
  input  logic    outPortRdy,
  input  logic    loadDone,
  input  logic    execDone,
  input  logic    unloadDone,
  input  status_t st,
  output strobe_t sb,
  output logic    loadStart,
  output bufIdx_t loadBuf,
  output logic    execStart,
  output bufIdx_t execInBuf,
  output bufIdx_t execOutBuf,
  output logic    unloadStart,
  output bufIdx_t unloadBuf
);
  logic anyInFree, anyOutFree;

  always_comb begin
    anyInFree     = |st.inFree;
    anyOutFree    = |st.outFree;
    sb.doLoad     = inPortRdy && !st.loadBusy && anyInFree;
    sb.loadIdx    = lowestFree(st.inFree);
    sb.doExec     = !st.coreBusy && st.execQValid && anyOutFree;
    sb.execOutIdx = lowestFree(st.outFree);
    sb.doUnload   = outPortRdy && !st.unloadBusy && st.outQValid;
    // R7: a done counts only while its phase runs
    sb.ldDoneOk   = loadDone && st.loadBusy;
    sb.exDoneOk   = execDone && st.coreBusy;
    sb.unDoneOk   = unloadDone && st.unloadBusy;
  end

  assign loadStart   = sb.doLoad;
  assign loadBuf     = sb.loadIdx;
  assign execStart   = sb.doExec;
  assign execInBuf   = st.execQHead;
  assign execOutBuf  = sb.execOutIdx;
  assign unloadStart = sb.doUnload;
  assign unloadBuf   = st.outQHead;

  // R8: starts are single-cycle pulses
  a_r8_load_pulse: assert property (@(posedge clk) disable iff (rst)
    loadStart |=> !loadStart);
  a_r8_exec_pulse: assert property (@(posedge clk) disable iff (rst)
    execStart |=> !execStart);
  a_r8_unload_pulse: assert property (@(posedge clk) disable iff (rst)
    unloadStart |=> !unloadStart);
  // R5: unload only toward a ready port
  a_r5_unload_port: assert property (@(posedge clk) disable iff (rst)
    unloadStart |-> outPortRdy);
endmodule

// File: rtl/dec_buf_seq_dpath.sv
module dec_buf_seq_dpath
  import dec_buf_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  strobe_t sb,
  output status_t st
);
  bufMask_t inFree, outFree;
  logic     loadBusy, coreBusy, unloadBusy;
  bufIdx_t  curLoad, curIn, curOut, curUnl;
  logic     execQValid, outQValid;
  bufIdx_t  execQHead, outQHead;

  always_ff @(posedge clk) begin
    if (rst) begin
      inFree     <= '1;
      outFree    <= '1;
      loadBusy   <= 1'b0;
      coreBusy   <= 1'b0;
      unloadBusy <= 1'b0;
      curLoad    <= '0;
      curIn      <= '0;
      curOut     <= '0;
      curUnl     <= '0;
    end else begin
      if (sb.doLoad) begin
        inFree[sb.loadIdx] <= 1'b0;
        loadBusy           <= 1'b1;
        curLoad            <= sb.loadIdx;
      end
      if (sb.ldDoneOk) loadBusy <= 1'b0;
      if (sb.doExec) begin
        outFree[sb.execOutIdx] <= 1'b0;
        coreBusy               <= 1'b1;
        curIn                  <= execQHead;
        curOut                 <= sb.execOutIdx;
      end
      if (sb.exDoneOk) begin
        inFree[curIn] <= 1'b1;   // R4: input freed at end of execution
        coreBusy      <= 1'b0;
      end
      if (sb.doUnload) begin
        unloadBusy <= 1'b1;
        curUnl     <= outQHead;
      end
      if (sb.unDoneOk) begin
        outFree[curUnl] <= 1'b1; // R5: output freed at end of unload
        unloadBusy      <= 1'b0;
      end
    end
  end

  dec_buf_seq_idxq #(.DEPTH(NBUF), .W(IDXW)) u_execQ (
    .clk(clk), .rst(rst), .push(sb.ldDoneOk), .pushData(curLoad),
    .pop(sb.doExec), .valid(execQValid), .head(execQHead));

  dec_buf_seq_idxq #(.DEPTH(NBUF), .W(IDXW)) u_outQ (
    .clk(clk), .rst(rst), .push(sb.exDoneOk), .pushData(curOut),
    .pop(sb.doUnload), .valid(outQValid), .head(outQHead));

  always_comb begin
    st.inFree     = inFree;
    st.outFree    = outFree;
    st.loadBusy   = loadBusy;
    st.coreBusy   = coreBusy;
    st.unloadBusy = unloadBusy;
    st.execQValid = execQValid;
    st.execQHead  = execQHead;
    st.outQValid  = outQValid;
    st.outQHead   = outQHead;
  end

  a_r2_load_into_free: assert property (@(posedge clk) disable iff (rst)
    sb.doLoad |-> inFree[sb.loadIdx] && !loadBusy);
  a_r3_exec_into_free: assert property (@(posedge clk) disable iff (rst)
    sb.doExec |-> outFree[sb.execOutIdx] && !coreBusy);
  a_r3_exec_input_loaded: assert property (@(posedge clk) disable iff (rst)
    sb.doExec |-> !inFree[execQHead]);
  a_r4_in_release: assert property (@(posedge clk) disable iff (rst)
    sb.exDoneOk |=> inFree[$past(curIn)]);
  a_r5_out_release: assert property (@(posedge clk) disable iff (rst)
    sb.unDoneOk |=> outFree[$past(curUnl)]);
  a_r5_unload_full: assert property (@(posedge clk) disable iff (rst)
    sb.doUnload |-> !outFree[outQHead]);
endmodule

// File: rtl/dec_buf_seq.sv
module dec_buf_seq
  import dec_buf_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            inPortRdy,
  output logic            loadStart,
  output logic [IDXW-1:0] loadBuf,
  input  logic            loadDone,
  output logic            execStart,
  output logic [IDXW-1:0] execInBuf,
  output logic [IDXW-1:0] execOutBuf,
  input  logic            execDone,
  input  logic            outPortRdy,
  output logic            unloadStart,
  output logic [IDXW-1:0] unloadBuf,
  input  logic            unloadDone
);
  strobe_t sb;
  status_t st;

  dec_buf_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inPortRdy(inPortRdy), .outPortRdy(outPortRdy),
    .loadDone(loadDone), .execDone(execDone), .unloadDone(unloadDone),
    .st(st), .sb(sb), .loadStart(loadStart), .loadBuf(loadBuf),
    .execStart(execStart), .execInBuf(execInBuf), .execOutBuf(execOutBuf),
    .unloadStart(unloadStart), .unloadBuf(unloadBuf));

  dec_buf_seq_dpath u_dpath (.clk(clk), .rst(rst), .sb(sb), .st(st));
endmodule

// File: tb/dec_buf_seq_bench.sv
module dec_buf_seq_bench;
  localparam int PERIOD = 10;
  localparam int RAND_CYCLES = 4000;

  logic clk = 1'b0, rst = 1'b1;
  logic inPortRdy = 0, outPortRdy = 0, loadDone = 0, execDone = 0, unloadDone = 0;
  logic loadStart, execStart, unloadStart;
  logic [0:0] loadBuf, execInBuf, execOutBuf, unloadBuf;

  int total = 0, bad = 0;
  bit finished = 0;

  // bench model state
  bit mInFree[2], mOutFree[2];
  bit mLdBusy, mCoreBusy, mUnBusy;
  int mLdBuf, mExIn, mExOut, mUnBuf;
  int qE[$], qO[$];
  bit eLoad, eExec, eUn;
  int eLoadBuf, eExOut;

  always #(PERIOD / 2) clk = ~clk;

  dec_buf_seq u_dec_buf_seq (
    .clk(clk), .rst(rst), .inPortRdy(inPortRdy), .loadStart(loadStart),
    .loadBuf(loadBuf), .loadDone(loadDone), .execStart(execStart),
    .execInBuf(execInBuf), .execOutBuf(execOutBuf), .execDone(execDone),
    .outPortRdy(outPortRdy), .unloadStart(unloadStart), .unloadBuf(unloadBuf),
    .unloadDone(unloadDone));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int lowIdx(input bit b0);
    return b0 ? 0 : 1;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 2; i++) begin mInFree[i] = 1; mOutFree[i] = 1; end
    mLdBusy = 0; mCoreBusy = 0; mUnBusy = 0;
    qE.delete(); qO.delete();
  endtask

  task automatic doReset();
    rst = 1; inPortRdy = 0; outPortRdy = 0;
    loadDone = 0; execDone = 0; unloadDone = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    modelReset();
    #1;
    chk("R1", "loadStart after reset", int'(loadStart), 0);
    chk("R1", "execStart after reset", int'(execStart), 0);
    chk("R1", "unloadStart after reset", int'(unloadStart), 0);
  endtask

  // one cycle: drive, compare against model, advance model to next edge
  task automatic step(input bit ir, input bit orr, input bit ld, input bit ex, input bit un);
    @(negedge clk);
    inPortRdy = ir; outPortRdy = orr; loadDone = ld; execDone = ex; unloadDone = un;
    #1;
    eLoad    = ir && !mLdBusy && (mInFree[0] || mInFree[1]);
    eLoadBuf = lowIdx(mInFree[0]);
    eExec    = !mCoreBusy && (qE.size() > 0) && (mOutFree[0] || mOutFree[1]);
    eExOut   = lowIdx(mOutFree[0]);
    eUn      = orr && !mUnBusy && (qO.size() > 0);
    chk("R2", "loadStart", int'(loadStart), int'(eLoad));
    if (eLoad) chk("R2", "loadBuf", int'(loadBuf), eLoadBuf);
    chk("R3", "execStart", int'(execStart), int'(eExec));
    if (eExec) begin
      chk("R3", "execOutBuf", int'(execOutBuf), eExOut);
      chk("R6", "execInBuf order", int'(execInBuf), qE[0]);
    end
    chk("R5", "unloadStart", int'(unloadStart), int'(eUn));
    if (eUn) chk("R6", "unloadBuf order", int'(unloadBuf), qO[0]);
    // dones accepted only while busy (R7)
    if (ld && mLdBusy) begin mLdBusy = 0; qE.push_back(mLdBuf); end
    if (ex && mCoreBusy) begin mInFree[mExIn] = 1; mCoreBusy = 0; qO.push_back(mExOut); end
    if (un && mUnBusy) begin mOutFree[mUnBuf] = 1; mUnBusy = 0; end
    if (eLoad) begin mInFree[eLoadBuf] = 0; mLdBusy = 1; mLdBuf = eLoadBuf; end
    if (eExec) begin
      mExIn = qE.pop_front(); mExOut = eExOut;
      mOutFree[eExOut] = 0; mCoreBusy = 1;
    end
    if (eUn) begin mUnBuf = qO.pop_front(); mUnBusy = 1; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ldRem, exRem, unRem;
    bit ld, ex, un;
    void'($urandom(32'd20240611));
    doReset();
    // directed: overlap, reuse and ordering
    step(1, 0, 0, 0, 0); chk("R1", "first loadBuf", int'(loadBuf), 0);
    step(1, 0, 0, 0, 0); chk("R8", "no restart while loading", int'(loadStart), 0);
    step(1, 0, 1, 0, 0); chk("R8", "no start in done cycle", int'(loadStart), 0);
    step(1, 0, 0, 0, 0);
    chk("R2", "second load uses buf1", int'(loadBuf), 1);
    chk("R3", "exec starts", int'(execStart), 1);
    chk("R3", "exec out lowest", int'(execOutBuf), 0);
    step(0, 0, 1, 0, 0);
    step(1, 0, 0, 0, 0); chk("R2", "no load when inputs full", int'(loadStart), 0);
    step(1, 0, 0, 1, 0); chk("R4", "no load before release edge", int'(loadStart), 0);
    step(1, 0, 0, 0, 0);
    chk("R4", "freed input reused", int'(loadStart), 1);
    chk("R4", "freed input index", int'(loadBuf), 0);
    chk("R5", "no unload port not ready", int'(unloadStart), 0);
    chk("R6", "exec reads buf1 next", int'(execInBuf), 1);
    step(0, 1, 0, 0, 0);
    chk("R5", "unload starts", int'(unloadStart), 1);
    chk("R6", "unload buf0 first", int'(unloadBuf), 0);
    step(0, 0, 1, 1, 1);
    step(0, 1, 0, 0, 0);
    chk("R6", "exec reads buf0", int'(execInBuf), 0);
    chk("R6", "unload buf1 next", int'(unloadBuf), 1);
    step(0, 0, 0, 1, 1);
    step(0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    // R7: spurious dones while idle
    step(0, 0, 1, 1, 1);
    step(1, 0, 0, 0, 0);
    chk("R7", "load after spurious dones", int'(loadStart), 1);
    chk("R7", "no exec after spurious done", int'(execStart), 0);
    chk("R7", "no unload after spurious done", int'(unloadStart), 0);

    // random phase with engine models
    doReset();
    ldRem = 0; exRem = 0; unRem = 0;
    for (int c = 0; c < RAND_CYCLES; c++) begin
      ld = (ldRem == 1) || (ldRem == 0 && ($urandom % 10 == 0));
      ex = (exRem == 1) || (exRem == 0 && ($urandom % 10 == 0));
      un = (unRem == 1) || (unRem == 0 && ($urandom % 10 == 0));
      step(($urandom % 10) < 7, ($urandom % 10) < 6, ld, ex, un);
      if (ldRem > 0) ldRem--;
      if (exRem > 0) exRem--;
      if (unRem > 0) unRem--;
      if (eLoad) ldRem = 1 + int'($urandom % 5);
      if (eExec) exRem = 1 + int'($urandom % 8);
      if (eUn)   unRem = 1 + int'($urandom % 6);
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule